// File: doc/BRIEF.md
# Double-Rate Late-Write SRAM Front End

This block models the device side of a synchronous SRAM that moves two words per clock cycle. Commands are taken once per cycle, and data moves on both halves of the cycle. The two halves are modelled with one internal clock at twice the cycle rate (`clk2x`) and a phase flag. The flag is cleared by reset, so the first `clk2x` edge after reset is the start of a cycle ("rise" edge), and the next edge is the mid-cycle edge ("fall" edge).

A command names a pair of words through an address that leaves out the lowest word-address bit. The even word moves on the rise beat and the odd word on the fall beat. Write data follows its command by one cycle (late write). Read data also appears one cycle after its command: the rise beat comes from a register loaded at the rise edge, and the fall beat from the same register reloaded at the fall edge. Write data is kept in a pending holder until the next rise edge, and reads of that pair are served from the holder.

Three chip enables qualify a command. The first is active low. The polarity of the other two comes from static select inputs. A pair of complementary echo clocks runs while the part is enabled. The echo clocks are stopped only by a deselect through the second or third enable.

Top module: `ddr_sram_fe`

## Requirements
- R1: Address, advance, write-enable and chip-enable inputs are used only at rise edges. Their values at fall edges have no effect on any output.
- R2: Word address bit 0 is implied. The rise beat of an operation carries the even word `{addr,0}` and the fall beat carries the odd word `{addr,1}`.
- R3: For a write loaded at rise edge N, `din_i` is stored as the even word at rise edge N+1 and as the odd word at the fall edge that follows. The bus is not driven (`dq_oe_o` low) during that data cycle.
- R4: For a read loaded at rise edge N, `dq_o` shows the even word after rise edge N+1 and the odd word after the following fall edge. `dq_oe_o` is high for that whole cycle.
- R5: With `adv_n_i` low, a command runs only if all three enables are active. Otherwise it is a deselect: no word is stored and the bus is not driven.
- R6: `en1_n_i` is active low. For `en2_i` and `en3_i`, a select input of 1 makes the enable active high and 0 makes it active low.
- R7: A new address is loaded only when `adv_n_i` is low. When `adv_n_i` is high after an active operation, the same kind of operation continues at address+1, wrapping modulo 2^AW. When it is high after a deselect, nothing happens.
- R8: A read of a pair whose write data is still pending returns the new data, including a read loaded in the cycle right after the write.
- R9: `dq_oe_o` is high exactly during the data cycle of a read. After a deselect, the cycle already in flight finishes, and the bus is released one cycle after the deselect.
- R10: The echo state is updated only by commands loaded with `adv_n_i` low. It turns off when the second or third enable is inactive and on when both are active; the first enable has no effect on it. The new state shows one cycle after the command. `cq_o` is high in the first half of each cycle and `cq_n_o` in the second half.
- R11: During reset and in the cycle after it, `dq_oe_o`, `cq_o` and `cq_n_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; successive edges alternate rise and fall beats |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW | Pair address (word address without bit 0) |
| adv_n_i | input | 1 | Low loads a new command; high continues a burst |
| we_n_i | input | 1 | Low selects write, high selects read |
| en1_n_i | input | 1 | First chip enable, active low |
| en2_i | input | 1 | Second chip enable, polarity from en2_pol_i |
| en3_i | input | 1 | Third chip enable, polarity from en3_pol_i |
| en2_pol_i | input | 1 | Static: 1 = en2_i active high, 0 = active low |
| en3_pol_i | input | 1 | Static: 1 = en3_i active high, 0 = active low |
| din_i | input | DW | Write data, one word per beat |
| dq_o | output | DW | Read data, one word per beat |
| dq_oe_o | output | 1 | Read data bus driven |
| cq_o | output | 1 | Echo clock, high in first half cycle when running |
| cq_n_o | output | 1 | Complementary echo clock, high in second half when running |

## Verification
The assertions assume that reset is released so that the phase flag is clear and that the polarity selects stay fixed around each command they qualify. The bench changes the polarity only between commands and applies every command in the half cycle before a rise edge. Commands of every kind are sampled with the phase flag, and each assertion expects its effect two or three double-rate edges later. The stimulus drives random values on all command inputs before each fall edge, so any use of those values would show up in the data or echo checks.

// File: rtl/ddr_sram_fe_pkg.sv
package ddr_sram_fe_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/ddr_sram_fe_decode.sv
module ddr_sram_fe_decode
   import ddr_sram_fe_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          clk2x,
   input  logic          rst_n,
   input  logic          rise,
   input  logic [AW-1:0] addr_i,
   input  logic          adv_n_i,
   input  logic          we_n_i,
   input  logic          en1_n_i,
   input  logic          en2_i,
   input  logic          en3_i,
   input  logic          en2_pol_i,
   input  logic          en3_pol_i,
   output op_e           op_q,
   output logic [AW-1:0] addr_q,
   output logic          echo_q
);
   logic          en2_on;
   logic          en3_on;
   logic          sel;
   op_e           op_d;
   logic [AW-1:0] addr_d;
   logic          echo_d;

   // polarity of the programmable enables is static
   assign en2_on = en2_pol_i ? en2_i : ~en2_i;
   assign en3_on = en3_pol_i ? en3_i : ~en3_i;
   assign sel    = ~en1_n_i & en2_on & en3_on;

   always_comb begin
      op_d   = OP_IDLE;
      addr_d = addr_q;
      echo_d = echo_q;
      if (!adv_n_i) begin
         echo_d = en2_on & en3_on;
         addr_d = addr_i;
         if (sel) begin
            op_d = we_n_i ? OP_READ : OP_WRITE;
         end
      end else if (op_q != OP_IDLE) begin
         // linear burst continuation
         op_d   = op_q;
         addr_d = addr_q + AW'(1);
      end
   end

   always_ff @(posedge clk2x) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         addr_q <= '0;
         echo_q <= 1'b0;
      end else if (rise) begin
         op_q   <= op_d;
         addr_q <= addr_d;
         echo_q <= echo_d;
      end
   end
endmodule

// File: rtl/ddr_sram_fe_store.sv
module ddr_sram_fe_store
   import ddr_sram_fe_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 18
) (
   input  logic          clk2x,
   input  logic          rst_n,
   input  logic          rise,
   input  op_e           op_q,
   input  logic [AW-1:0] addr_q,
   input  logic [DW-1:0] din_i,
   output logic [DW-1:0] rd_w0,
   output logic [DW-1:0] rd_w1
);
   localparam int ROWS  = 1 << AW;
   localparam int BEATS = 2;

   logic          cap_v;
   logic [AW-1:0] cap_addr;
   logic [DW-1:0] wd [BEATS];
   logic [DW-1:0] rd_b [BEATS];
   logic          fwd;

   // pending late-write pair: address at rise, even word at rise,
   // odd word at the following fall, committed at the next rise
   always_ff @(posedge clk2x) begin
      if (!rst_n) begin
         cap_v    <= 1'b0;
         cap_addr <= '0;
      end else if (rise) begin
         cap_v    <= (op_q == OP_WRITE);
         cap_addr <= addr_q;
      end
   end

   always_ff @(posedge clk2x) begin
      if (rise && (op_q == OP_WRITE)) begin
         wd[0] <= din_i;
      end
      if (!rise && cap_v) begin
         wd[1] <= din_i;
      end
   end

   assign fwd = cap_v && (cap_addr == addr_q);

   for (genvar b = 0; b < BEATS; b++) begin : g_bank
      logic [DW-1:0] mem [ROWS];
      always_ff @(posedge clk2x) begin
         if (rise && cap_v) begin
            mem[cap_addr] <= wd[b];
         end
      end
      assign rd_b[b] = fwd ? wd[b] : mem[addr_q];
   end

   assign rd_w0 = rd_b[0];
   assign rd_w1 = rd_b[1];
endmodule

// File: rtl/ddr_sram_fe_rdout.sv
module ddr_sram_fe_rdout #(
   parameter int DW = 18
) (
   input  logic          clk2x,
   input  logic          rst_n,
   input  logic          rise,
   input  logic          rd_req,
   input  logic          echo_q,
   input  logic [DW-1:0] rd_w0,
   input  logic [DW-1:0] rd_w1,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe_o,
   output logic          cq_o,
   output logic          cq_n_o
);
   logic [DW-1:0] dq_r;
   logic [DW-1:0] odd_hold;
   logic          oe_r;
   logic          cq_run;

   always_ff @(posedge clk2x) begin
      if (!rst_n) begin
         dq_r     <= '0;
         odd_hold <= '0;
         oe_r     <= 1'b0;
         cq_run   <= 1'b0;
      end else if (rise) begin
         dq_r     <= rd_w0;
         odd_hold <= rd_w1;
         oe_r     <= rd_req;
         cq_run   <= echo_q;
      end else begin
         dq_r     <= odd_hold;
      end
   end

   assign dq_o    = dq_r;
   assign dq_oe_o = oe_r;
   assign cq_o    = cq_run & ~rise;
   assign cq_n_o  = cq_run & rise;
endmodule

// File: rtl/ddr_sram_fe.sv
module ddr_sram_fe
   import ddr_sram_fe_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 18
) (
   input  logic          clk2x,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic          adv_n_i,
   input  logic          we_n_i,
   input  logic          en1_n_i,
   input  logic          en2_i,
   input  logic          en3_i,
   input  logic          en2_pol_i,
   input  logic          en3_pol_i,
   input  logic [DW-1:0] din_i,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe_o,
   output logic          cq_o,
   output logic          cq_n_o
);
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("ddr_sram_fe: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ddr_sram_fe: DW must be positive");
   end

   logic          ph_q;
   logic          rise;
   op_e           op_q;
   logic [AW-1:0] addr_q;
   logic          echo_q;
   logic [DW-1:0] rd_w0;
   logic [DW-1:0] rd_w1;

   always_ff @(posedge clk2x) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end
   assign rise = ~ph_q;

   ddr_sram_fe_decode #(.AW(AW)) i_decode (
      .clk2x     (clk2x),
      .rst_n     (rst_n),
      .rise      (rise),
      .addr_i    (addr_i),
      .adv_n_i   (adv_n_i),
      .we_n_i    (we_n_i),
      .en1_n_i   (en1_n_i),
      .en2_i     (en2_i),
      .en3_i     (en3_i),
      .en2_pol_i (en2_pol_i),
      .en3_pol_i (en3_pol_i),
      .op_q      (op_q),
      .addr_q    (addr_q),
      .echo_q    (echo_q)
   );

   ddr_sram_fe_store #(.AW(AW), .DW(DW)) i_store (
      .clk2x  (clk2x),
      .rst_n  (rst_n),
      .rise   (rise),
      .op_q   (op_q),
      .addr_q (addr_q),
      .din_i  (din_i),
      .rd_w0  (rd_w0),
      .rd_w1  (rd_w1)
   );

   ddr_sram_fe_rdout #(.DW(DW)) i_rdout (
      .clk2x   (clk2x),
      .rst_n   (rst_n),
      .rise    (rise),
      .rd_req  (op_q == OP_READ),
      .echo_q  (echo_q),
      .rd_w0   (rd_w0),
      .rd_w1   (rd_w1),
      .dq_o    (dq_o),
      .dq_oe_o (dq_oe_o),
      .cq_o    (cq_o),
      .cq_n_o  (cq_n_o)
   );
endmodule

// File: rtl/ddr_sram_fe_chk.sv
module ddr_sram_fe_chk (
   input logic clk2x,
   input logic rst_n,
   input logic ph,
   input logic adv_n_i,
   input logic we_n_i,
   input logic en1_n_i,
   input logic en2_i,
   input logic en3_i,
   input logic en2_pol_i,
   input logic en3_pol_i,
   input logic dq_oe_o,
   input logic cq_o,
   input logic cq_n_o
);
   logic e2a;
   logic e3a;
   logic load;
   assign e2a  = (en2_i == en2_pol_i);
   assign e3a  = (en3_i == en3_pol_i);
   assign load = rst_n && !ph && !adv_n_i;

   AST_READ_DRIVES: assert property (@(posedge clk2x) disable iff (!rst_n)
      (load && !en1_n_i && e2a && e3a && we_n_i) |=> ##2 dq_oe_o); // R4

   AST_WRITE_NO_DRIVE: assert property (@(posedge clk2x) disable iff (!rst_n)
      (load && !en1_n_i && e2a && e3a && !we_n_i) |=> ##2 !dq_oe_o); // R3

   AST_DESELECT_RELEASES: assert property (@(posedge clk2x) disable iff (!rst_n)
      (load && !(!en1_n_i && e2a && e3a)) |=> ##2 !dq_oe_o); // R9

   AST_OE_HELD_OVER_FALL: assert property (@(posedge clk2x) disable iff (!rst_n)
      (rst_n && ph) |=> $stable(dq_oe_o)); // R9

   AST_ECHO_KEEPS_ON_E1: assert property (@(posedge clk2x) disable iff (!rst_n)
      (load && en1_n_i && e2a && e3a) |=> ##2 cq_o); // R10

   AST_ECHO_STOPS: assert property (@(posedge clk2x) disable iff (!rst_n)
      (load && !(e2a && e3a)) |=> ##2 (!cq_o && !cq_n_o)); // R10

   AST_RESET_QUIET: assert property (@(posedge clk2x)
      !rst_n |=> (!dq_oe_o && !cq_o && !cq_n_o)); // R11
endmodule

bind ddr_sram_fe ddr_sram_fe_chk i_chk (
   .clk2x     (clk2x),
   .rst_n     (rst_n),
   .ph        (ph_q),
   .adv_n_i   (adv_n_i),
   .we_n_i    (we_n_i),
   .en1_n_i   (en1_n_i),
   .en2_i     (en2_i),
   .en3_i     (en3_i),
   .en2_pol_i (en2_pol_i),
   .en3_pol_i (en3_pol_i),
   .dq_oe_o   (dq_oe_o),
   .cq_o      (cq_o),
   .cq_n_o    (cq_n_o)
);

// File: tb/test_ddr_sram_fe.sv
`timescale 1ns/1ps
module test_ddr_sram_fe;
   localparam int AW   = 4;
   localparam int DW   = 18;
   localparam int ROWS = 1 << AW;

   logic          clk2x = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          adv_n, we_n, en1_n, en2, en3, pol2, pol3;
   logic [DW-1:0] din;
   logic [DW-1:0] dq;
   logic          dq_oe, cq, cq_n;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   // bench model state
   logic [DW-1:0] m0 [ROWS];
   logic [DW-1:0] m1 [ROWS];
   bit            pv = 0;
   bit            pwr = 0;
   logic [AW-1:0] paddr = '0;
   bit            echo_st = 0;

   always #5 clk2x = ~clk2x;

   ddr_sram_fe #(.AW(AW), .DW(DW)) i_ddr_sram_fe (
      .clk2x(clk2x), .rst_n(rst_n), .addr_i(addr), .adv_n_i(adv_n),
      .we_n_i(we_n), .en1_n_i(en1_n), .en2_i(en2), .en3_i(en3),
      .en2_pol_i(pol2), .en3_pol_i(pol3), .din_i(din),
      .dq_o(dq), .dq_oe_o(dq_oe), .cq_o(cq), .cq_n_o(cq_n)
   );

   function automatic logic enc(input logic act, input logic pol);
      return pol ? act : ~act;
   endfunction

   task automatic chk(input bit ok, input string tg,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tg, act, exp);
      end
   endtask

   // one command cycle; s1..s3 are logical enable states (1 = active);
   // tg names the requirement for the read data observed in this cycle
   task automatic cyc(input logic a_n, input logic w_n, input logic s1,
                      input logic s2, input logic s3, input logic [AW-1:0] a,
                      input string tg);
      logic [DW-1:0] d0, d1, e0, e1;
      bit eo, ec, nv, nwr, nec;
      logic [AW-1:0] na;
      d0 = DW'($urandom);
      d1 = DW'($urandom);
      eo = pv && !pwr;
      ec = echo_st;
      e0 = m0[paddr];
      e1 = m1[paddr];
      if (pv && pwr) begin
         m0[paddr] = d0;
         m1[paddr] = d1;
      end
      na = paddr;
      if (!a_n) begin
         nec = s2 && s3;
         nv  = s1 && s2 && s3;
         nwr = !w_n;
         na  = a;
      end else begin
         nec = echo_st;
         nv  = pv;
         nwr = pwr;
         na  = paddr + AW'(1);
      end
      adv_n = a_n; we_n = w_n; en1_n = ~s1;
      en2 = enc(s2, pol2); en3 = enc(s3, pol3);
      addr = a; din = d0;
      @(posedge clk2x);
      @(negedge clk2x);
      chk(dq_oe == eo, "R9", 32'(dq_oe), 32'(eo));
      if (eo) chk(dq == e0, tg, 32'(dq), 32'(e0));
      chk(cq == ec, "R10", 32'(cq), 32'(ec));
      chk(cq_n == 1'b0, "R10", 32'(cq_n), 32'd0);
      // R1: random command inputs around the fall edge
      din = d1;
      adv_n = 1'($urandom); we_n = 1'($urandom); en1_n = 1'($urandom);
      en2 = 1'($urandom); en3 = 1'($urandom); addr = AW'($urandom);
      @(posedge clk2x);
      @(negedge clk2x);
      chk(dq_oe == eo, "R9", 32'(dq_oe), 32'(eo));
      if (eo) chk(dq == e1, tg, 32'(dq), 32'(e1));
      chk(cq == 1'b0, "R10", 32'(cq), 32'd0);
      chk(cq_n == ec, "R10", 32'(cq_n), 32'(ec));
      pv = nv; pwr = nwr; paddr = na; echo_st = nec;
   endtask

   initial begin
      #(10 * 100000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250));
      rst_n = 1'b0; pol2 = 1'b1; pol3 = 1'b1;
      adv_n = 1'b1; we_n = 1'b1; en1_n = 1'b1; en2 = 1'b0; en3 = 1'b0;
      addr = '0; din = '0;
      repeat (4) @(posedge clk2x);
      @(negedge clk2x);
      chk(!dq_oe && !cq && !cq_n, "R11", {29'd0, dq_oe, cq, cq_n}, 32'd0);
      rst_n = 1'b1;

      // R3: fill every pair, then flush with an e1 deselect
      for (int a = 0; a < ROWS; a++) cyc(1'b0, 1'b0, 1, 1, 1, AW'(a), "R3");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R3");
      // R2/R4: read back every pair, even word then odd word
      for (int a = 0; a < ROWS; a++) cyc(1'b0, 1'b1, 1, 1, 1, AW'(a), "R2/R4");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R2/R4");

      // R7: write burst wrapping past the top, then read burst
      cyc(1'b0, 1'b0, 1, 1, 1, AW'(ROWS - 2), "R7");
      repeat (3) cyc(1'b1, 1'b1, 1, 1, 1, '0, "R7");
      cyc(1'b0, 1'b1, 1, 1, 1, AW'(ROWS - 2), "R7");
      repeat (3) cyc(1'b1, 1'b0, 0, 0, 0, '0, "R7");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R7");
      // R7: advance after deselect does nothing
      repeat (2) cyc(1'b1, 1'b1, 1, 1, 1, '0, "R7");
      cyc(1'b0, 1'b1, 1, 1, 1, 4'd5, "R7");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R7");

      // R8: read right after write of the same pair, and one cycle later
      cyc(1'b0, 1'b0, 1, 1, 1, 4'd9, "R8");
      cyc(1'b0, 1'b1, 1, 1, 1, 4'd9, "R8");
      cyc(1'b0, 1'b0, 1, 1, 1, 4'd9, "R8");
      cyc(1'b0, 1'b1, 1, 1, 1, 4'd2, "R8");
      cyc(1'b0, 1'b1, 1, 1, 1, 4'd9, "R8");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R8");

      // R5: deselected writes store nothing, deselected read drives nothing
      cyc(1'b0, 1'b0, 1, 0, 1, 4'd3, "R5");
      cyc(1'b0, 1'b0, 0, 1, 1, 4'd3, "R5");
      cyc(1'b0, 1'b1, 1, 1, 0, 4'd3, "R5");
      cyc(1'b0, 1'b1, 1, 1, 1, 4'd3, "R5");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R5");

      // R10: echo stops on e2/e3, not on e1, restarts on reselect
      cyc(1'b0, 1'b1, 1, 1, 0, '0, "R10");
      cyc(1'b1, 1'b1, 1, 1, 1, '0, "R10");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R10");
      cyc(1'b0, 1'b1, 1, 0, 1, '0, "R10");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R10");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R10");

      // R6: inverted polarity for both programmable enables
      pol2 = 1'b0; pol3 = 1'b0;
      cyc(1'b0, 1'b0, 1, 1, 1, 4'd7, "R6");
      cyc(1'b0, 1'b1, 1, 1, 1, 4'd7, "R6");
      cyc(1'b0, 1'b0, 1, 0, 1, 4'd7, "R6");
      cyc(1'b0, 1'b1, 1, 1, 1, 4'd7, "R6");
      cyc(1'b0, 1'b1, 0, 1, 1, '0, "R6");

      // R1/R6 random traffic with polarity changed between segments
      for (int i = 0; i < 3000; i++) begin
         if (i % 500 == 0) begin
            pol2 = 1'($urandom); pol3 = 1'($urandom);
         end
         cyc(($urandom % 4) == 0, 1'($urandom), ($urandom % 8) != 0,
             ($urandom % 10) != 0, ($urandom % 10) != 0,
             AW'($urandom), "R1/R6");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule